// File: doc/BRIEF.md
# Cartridge Bank Address Translator

This block sits between the console buses and the cartridge memories and turns CPU and PPU addresses into physical memory addresses. Four 5-bit bank registers drive the translation: a control register, two character bank registers and a program bank register. All four are held elsewhere. The block only reads them. Every output is a pure function of the current register values and bus addresses, so a new address appears in the same cycle with no added latency.

The CPU space from 0x8000 to 0xFFFF is split into two 16 KB windows. The control register chooses one of three program layouts:
- the lower window switchable and the upper window fixed to the last bank;
- the lower window fixed to the first bank and the upper window switchable;
- one 32 KB pair.

Bit 4 of the lower character register adds an outer 256 KB step to every program bank. The 8 KB pattern space is mapped either as one 8 KB bank or as two independent 4 KB banks. The block also:
- derives the nametable page bit from the mirroring field;
- decodes the 0x6000–0x7FFF work-RAM window, including its enable and its 8 KB bank.

When work RAM is disabled, writes are blocked and reads return the last value seen on the data bus.

Top module: `cart_bank_xlat`

## Requirements
- R1: Bit 4 of `chr_lo_reg` adds 16 to every 16 KB program bank number, in every layout and for the fixed banks as well. The sum is formed before wrapping.
- R2: When `ctrl_reg[3:2]` is 2'b11, the 0x8000 window uses `prg_reg` and the 0xC000 window uses bank 15.
- R3: When `ctrl_reg[3:2]` is 2'b10, the 0x8000 window uses bank 0 and the 0xC000 window uses `prg_reg`.
- R4: When `ctrl_reg[3]` is 0, the 0x8000 window uses `prg_reg` with bit 0 cleared and the 0xC000 window uses that value plus one.
- R5: `prg_rom_addr` is {bank mod PRG_BANKS16, cpu_addr[13:0]}. `prg_rom_ce` equals `cpu_addr[15]`. Bank numbers at or above PRG_BANKS16 wrap around.
- R6: When `ctrl_reg[4]` is 1, PPU addresses with bit 12 clear use 4 KB bank `chr_lo_reg` and those with bit 12 set use `chr_hi_reg`.
- R7: When `ctrl_reg[4]` is 0, the 8 KB bank `chr_lo_reg>>1` is used, so the 4 KB bank is {chr_lo_reg[4:1], ppu_addr[12]}. In both character modes `chr_addr` is {4 KB bank mod CHR_BANKS4, ppu_addr[11:0]}.
- R8: `ctrl_reg[1:0]` selects the nametable page `nt_page`:
  - 0 gives a constant 0;
  - 1 gives a constant 1;
  - 2 (vertical) gives `ppu_addr[10]`;
  - 3 (horizontal) gives `ppu_addr[11]`.

  `mirror_mode` repeats the field.
- R9: When `prg_reg[4]` is 1, work RAM is disabled: `wram_ce` and `wram_we` are 0 and `wram_rd_data` equals `bus_last`. When it is 0, `wram_rd_data` equals `wram_rdata`.
- R10: With two 8 KB work-RAM banks, `wram_addr[13]` is taken from `chr_lo_reg[4]` when `ctrl_reg[4]` is 1, and from `chr_lo_reg[3]` otherwise. `wram_addr[12:0]` is `cpu_addr[12:0]`.
- R11: `wram_ce` is 1 only for CPU addresses 0x6000–0x7FFF with work RAM enabled. `wram_we` is `cpu_we` gated by `wram_ce`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctrl_reg | input | 5 | Control register: mirroring [1:0], program layout [3:2], character mode [4] |
| chr_lo_reg | input | 5 | Lower character bank register; bit 4 also gives the outer program step |
| chr_hi_reg | input | 5 | Upper character bank register (4 KB mode) |
| prg_reg | input | 5 | Program bank register; bit 4 disables work RAM |
| cpu_addr | input | 16 | CPU address |
| cpu_we | input | 1 | CPU write strobe |
| wram_rdata | input | 8 | Data read from work RAM |
| bus_last | input | 8 | Last value seen on the CPU data bus |
| ppu_addr | input | 13 | PPU address |
| prg_rom_ce | output | 1 | Program ROM select (cpu_addr[15]) |
| prg_rom_addr | output | PRG_BW+14 (19) | Physical program ROM address |
| chr_addr | output | CHR_BW+12 (17) | Physical character memory address |
| mirror_mode | output | 2 | Current mirroring field |
| nt_page | output | 1 | Nametable page select |
| wram_ce | output | 1 | Work RAM access enabled |
| wram_we | output | 1 | Work RAM write enable |
| wram_addr | output | WRAM_AW (14) | Work RAM address |
| wram_rd_data | output | 8 | Data returned to the CPU for work-RAM reads |

## Verification
The bench checks that the outer program step is added to the fixed banks too; a design that applied it only to switchable banks would map the last window into the wrong 256 KB half. It checks that a large bank number plus the step wraps modulo the ROM size. It also checks that the 32 KB pair clears bit 0 before adding one and the step, so an odd register value does not shift the pair by one bank. Each mirroring code is probed with nametable addresses whose bits 10 and 11 differ, which catches a swapped vertical and horizontal mapping. The work-RAM bank bit is probed in both character modes, and the disabled case is checked for a blocked write and for bus-hold read data; a reversed enable polarity would let writes through.

// File: rtl/cart_bank_xlat_pkg.sv
package cart_bank_xlat_pkg;

  typedef enum logic [1:0] {
    MIR_ONE_LO = 2'd0,
    MIR_ONE_HI = 2'd1,
    MIR_VERT   = 2'd2,
    MIR_HORZ   = 2'd3
  } mirror_e;

  typedef enum logic [1:0] {
    PLAY_PAIR0 = 2'd0,
    PLAY_PAIR1 = 2'd1,
    PLAY_FIXLO = 2'd2,
    PLAY_FIXHI = 2'd3
  } prg_layout_e;

  localparam int BANK_SUM_W = 7;
  localparam logic [BANK_SUM_W-1:0] LAST_FIXED_BANK = 7'd15;

endpackage

// File: rtl/cart_prg_map.sv
module cart_prg_map
  import cart_bank_xlat_pkg::*;
#(
  parameter int PRG_BW = 5
) (
  input  logic [1:0]        layout,
  input  logic [4:0]        bank_reg,
  input  logic              outer_bit,
  input  logic              win_hi,
  output logic [PRG_BW-1:0] bank
);

  logic [BANK_SUM_W-1:0] step;
  logic [BANK_SUM_W-1:0] sel;
  logic [BANK_SUM_W-1:0] pair_base;
  logic [BANK_SUM_W-1:0] raw;

  always_comb begin
    step      = {2'b00, outer_bit, 4'b0000};
    sel       = {2'b00, bank_reg};
    pair_base = {2'b00, bank_reg[4:1], 1'b0};
    unique case (prg_layout_e'(layout))
      PLAY_FIXHI: raw = win_hi ? (LAST_FIXED_BANK + step) : (sel + step);
      PLAY_FIXLO: raw = win_hi ? (sel + step) : step;
      default:    raw = pair_base + step + {{(BANK_SUM_W-1){1'b0}}, win_hi};
    endcase
    bank = raw[PRG_BW-1:0];
  end

endmodule

// File: rtl/cart_chr_map.sv
module cart_chr_map #(
  parameter int CHR_BW = 5
) (
  input  logic              four_k,
  input  logic [4:0]        lo_reg,
  input  logic [4:0]        hi_reg,
  input  logic              half_sel,
  output logic [CHR_BW-1:0] bank
);

  logic [4:0] raw;

  always_comb begin
    if (four_k) raw = half_sel ? hi_reg : lo_reg;
    else        raw = {lo_reg[4:1], half_sel};
    bank = raw[CHR_BW-1:0];
  end

endmodule

// File: rtl/cart_nt_mirror.sv
module cart_nt_mirror
  import cart_bank_xlat_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       a10,
  input  logic       a11,
  output logic       page
);

  always_comb begin
    unique case (mirror_e'(mode))
      MIR_ONE_LO: page = 1'b0;
      MIR_ONE_HI: page = 1'b1;
      MIR_VERT:   page = a10;
      default:    page = a11;
    endcase
  end

endmodule

// File: rtl/cart_wram_gate.sv
module cart_wram_gate #(
  parameter int WRAM_BANKS8 = 2,
  parameter int WRAM_AW     = 14
) (
  input  logic [15:0]        cpu_addr,
  input  logic               cpu_we,
  input  logic               disable_bit,
  input  logic               four_k,
  input  logic [4:0]         lo_reg,
  input  logic [7:0]         rdata,
  input  logic [7:0]         bus_last,
  output logic               ce,
  output logic               we,
  output logic [WRAM_AW-1:0] addr,
  output logic [7:0]         rd_data
);

  logic in_win;

  always_comb begin
    in_win  = (cpu_addr[15:13] == 3'b011);
    ce      = in_win && !disable_bit;
    we      = ce && cpu_we;
    rd_data = disable_bit ? bus_last : rdata;
  end

  generate
    if (WRAM_BANKS8 > 1) begin : g_banked
      logic bank_bit;
      always_comb begin
        bank_bit = four_k ? lo_reg[4] : lo_reg[3];
        addr     = {bank_bit, cpu_addr[12:0]};
      end
    end else begin : g_flat
      always_comb addr = cpu_addr[12:0];
    end
  endgenerate

endmodule

// File: rtl/cart_bank_xlat.sv
module cart_bank_xlat #(
  parameter int PRG_BANKS16 = 32,
  parameter int CHR_BANKS4  = 32,
  parameter int WRAM_BANKS8 = 2,
  localparam int PRG_BW  = $clog2(PRG_BANKS16),
  localparam int CHR_BW  = $clog2(CHR_BANKS4),
  localparam int PRG_AW  = PRG_BW + 14,
  localparam int CHR_AW  = CHR_BW + 12,
  localparam int WRAM_AW = (WRAM_BANKS8 > 1) ? 14 : 13
) (
  input  logic [4:0]         ctrl_reg,
  input  logic [4:0]         chr_lo_reg,
  input  logic [4:0]         chr_hi_reg,
  input  logic [4:0]         prg_reg,
  input  logic [15:0]        cpu_addr,
  input  logic               cpu_we,
  input  logic [7:0]         wram_rdata,
  input  logic [7:0]         bus_last,
  input  logic [12:0]        ppu_addr,
  output logic               prg_rom_ce,
  output logic [PRG_AW-1:0]  prg_rom_addr,
  output logic [CHR_AW-1:0]  chr_addr,
  output logic [1:0]         mirror_mode,
  output logic               nt_page,
  output logic               wram_ce,
  output logic               wram_we,
  output logic [WRAM_AW-1:0] wram_addr,
  output logic [7:0]         wram_rd_data
);

  logic [PRG_BW-1:0] prg_bank;
  logic [CHR_BW-1:0] chr_bank;

  cart_prg_map #(.PRG_BW(PRG_BW)) u_prg (
    .layout    (ctrl_reg[3:2]),
    .bank_reg  (prg_reg),
    .outer_bit (chr_lo_reg[4]),
    .win_hi    (cpu_addr[14]),
    .bank      (prg_bank)
  );

  cart_chr_map #(.CHR_BW(CHR_BW)) u_chr (
    .four_k   (ctrl_reg[4]),
    .lo_reg   (chr_lo_reg),
    .hi_reg   (chr_hi_reg),
    .half_sel (ppu_addr[12]),
    .bank     (chr_bank)
  );

  cart_nt_mirror u_nt (
    .mode (ctrl_reg[1:0]),
    .a10  (ppu_addr[10]),
    .a11  (ppu_addr[11]),
    .page (nt_page)
  );

  cart_wram_gate #(.WRAM_BANKS8(WRAM_BANKS8), .WRAM_AW(WRAM_AW)) u_wram (
    .cpu_addr    (cpu_addr),
    .cpu_we      (cpu_we),
    .disable_bit (prg_reg[4]),
    .four_k      (ctrl_reg[4]),
    .lo_reg      (chr_lo_reg),
    .rdata       (wram_rdata),
    .bus_last    (bus_last),
    .ce          (wram_ce),
    .we          (wram_we),
    .addr        (wram_addr),
    .rd_data     (wram_rd_data)
  );

  always_comb begin
    prg_rom_ce   = cpu_addr[15];
    prg_rom_addr = {prg_bank, cpu_addr[13:0]};
    chr_addr     = {chr_bank, ppu_addr[11:0]};
    mirror_mode  = ctrl_reg[1:0];
  end

endmodule

// File: rtl/cart_bank_xlat_chk.sv
module cart_bank_xlat_chk #(
  parameter int PRG_BANKS16 = 32,
  parameter int CHR_BANKS4  = 32,
  parameter int WRAM_BANKS8 = 2,
  localparam int PRG_BW  = $clog2(PRG_BANKS16),
  localparam int CHR_BW  = $clog2(CHR_BANKS4),
  localparam int PRG_AW  = PRG_BW + 14,
  localparam int CHR_AW  = CHR_BW + 12,
  localparam int WRAM_AW = (WRAM_BANKS8 > 1) ? 14 : 13
) (
  input logic [4:0]         ctrl_reg,
  input logic [4:0]         chr_lo_reg,
  input logic [4:0]         prg_reg,
  input logic [15:0]        cpu_addr,
  input logic               cpu_we,
  input logic [7:0]         bus_last,
  input logic [12:0]        ppu_addr,
  input logic [PRG_AW-1:0]  prg_rom_addr,
  input logic [CHR_AW-1:0]  chr_addr,
  input logic               nt_page,
  input logic               wram_ce,
  input logic               wram_we,
  input logic [7:0]         wram_rd_data
);

  logic [6:0] fix_hi;
  always_comb fix_hi = 7'd15 + {2'b00, chr_lo_reg[4], 4'b0000};

  always_comb begin
    if (ctrl_reg[3:2] == 2'b11 && cpu_addr[15:14] == 2'b11)
      AST_FIXED_LAST_BANK: assert (prg_rom_addr[PRG_AW-1:14] == fix_hi[PRG_BW-1:0]); // R2
    if (ctrl_reg[3] == 1'b0)
      AST_PAIR_LSB_FOLLOWS_WINDOW: assert (prg_rom_addr[14] == cpu_addr[14]); // R4
    AST_PRG_OFFSET_PASS: assert (prg_rom_addr[13:0] == cpu_addr[13:0]); // R5
    if (ctrl_reg[4] == 1'b0)
      AST_CHR8_HALF_BIT: assert (chr_addr[12] == ppu_addr[12]); // R7
    if (ctrl_reg[1] == 1'b0)
      AST_SINGLE_SCREEN: assert (nt_page == ctrl_reg[0]); // R8
    if (prg_reg[4])
      AST_WRAM_DISABLED: assert (!wram_we && !wram_ce && wram_rd_data == bus_last); // R9
    if (cpu_addr[15:13] != 3'b011)
      AST_WRAM_OUTSIDE: assert (!wram_ce && !wram_we); // R11
    if (!cpu_we)
      AST_WRAM_NO_WRITE: assert (!wram_we); // R11
  end

endmodule

bind cart_bank_xlat cart_bank_xlat_chk #(
  .PRG_BANKS16 (PRG_BANKS16),
  .CHR_BANKS4  (CHR_BANKS4),
  .WRAM_BANKS8 (WRAM_BANKS8)
) u_chk (
  .ctrl_reg     (ctrl_reg),
  .chr_lo_reg   (chr_lo_reg),
  .prg_reg      (prg_reg),
  .cpu_addr     (cpu_addr),
  .cpu_we       (cpu_we),
  .bus_last     (bus_last),
  .ppu_addr     (ppu_addr),
  .prg_rom_addr (prg_rom_addr),
  .chr_addr     (chr_addr),
  .nt_page      (nt_page),
  .wram_ce      (wram_ce),
  .wram_we      (wram_we),
  .wram_rd_data (wram_rd_data)
);

// File: tb/cart_bank_xlat_test.sv
module cart_bank_xlat_test;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [4:0]  ctrl_reg, chr_lo_reg, chr_hi_reg, prg_reg;
  logic [15:0] cpu_addr;
  logic        cpu_we;
  logic [7:0]  wram_rdata, bus_last;
  logic [12:0] ppu_addr;
  logic        prg_rom_ce;
  logic [18:0] prg_rom_addr;
  logic [16:0] chr_addr;
  logic [1:0]  mirror_mode;
  logic        nt_page;
  logic        wram_ce, wram_we;
  logic [13:0] wram_addr;
  logic [7:0]  wram_rd_data;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  cart_bank_xlat uut (
    .ctrl_reg(ctrl_reg), .chr_lo_reg(chr_lo_reg), .chr_hi_reg(chr_hi_reg),
    .prg_reg(prg_reg), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .wram_rdata(wram_rdata), .bus_last(bus_last), .ppu_addr(ppu_addr),
    .prg_rom_ce(prg_rom_ce), .prg_rom_addr(prg_rom_addr), .chr_addr(chr_addr),
    .mirror_mode(mirror_mode), .nt_page(nt_page), .wram_ce(wram_ce),
    .wram_we(wram_we), .wram_addr(wram_addr), .wram_rd_data(wram_rd_data)
  );

  typedef struct packed {
    logic [4:0]  ctrl;
    logic [4:0]  lo;
    logic [4:0]  hi;
    logic [4:0]  prg;
    logic [15:0] cpu;
    logic [12:0] ppu;
    logic [18:0] exp_prg;
    logic [16:0] exp_chr;
    logic        exp_nt;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{5'h0C, 5'h00, 5'h00, 5'h03, 16'h8123, 13'h0456, 19'h0C123, 17'h00456, 1'b0},
    '{5'h0C, 5'h00, 5'h00, 5'h03, 16'hC010, 13'h1FFF, 19'h3C010, 17'h01FFF, 1'b0},
    '{5'h0D, 5'h10, 5'h00, 5'h02, 16'hC000, 13'h0800, 19'h7C000, 17'h10800, 1'b1},
    '{5'h0D, 5'h10, 5'h00, 5'h02, 16'h8000, 13'h1000, 19'h48000, 17'h11000, 1'b1},
    '{5'h0A, 5'h00, 5'h00, 5'h05, 16'h8ABC, 13'h0400, 19'h00ABC, 17'h00400, 1'b1},
    '{5'h0A, 5'h00, 5'h00, 5'h05, 16'hE001, 13'h0800, 19'h16001, 17'h00800, 1'b0},
    '{5'h13, 5'h07, 5'h1A, 5'h09, 16'h8004, 13'h0ABC, 19'h20004, 17'h07ABC, 1'b1},
    '{5'h13, 5'h07, 5'h1A, 5'h09, 16'hC004, 13'h1234, 19'h24004, 17'h1A234, 1'b0},
    '{5'h06, 5'h13, 5'h00, 5'h0B, 16'hC000, 13'h1010, 19'h6C000, 17'h13010, 1'b0},
    '{5'h06, 5'h10, 5'h00, 5'h1F, 16'hC000, 13'h0000, 19'h3C000, 17'h10000, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] c, input logic [4:0] l, input logic [4:0] h,
                       input logic [4:0] p, input logic [15:0] a, input logic [12:0] v,
                       input logic w);
    @(posedge clk);
    #1;
    ctrl_reg = c; chr_lo_reg = l; chr_hi_reg = h; prg_reg = p;
    cpu_addr = a; ppu_addr = v; cpu_we = w;
    @(negedge clk);
  endtask

  initial begin
    ctrl_reg = '0; chr_lo_reg = '0; chr_hi_reg = '0; prg_reg = '0;
    cpu_addr = '0; ppu_addr = '0; cpu_we = 1'b0;
    wram_rdata = 8'h5A; bus_last = 8'hC3;
    @(negedge clk);
    // all-zero inputs
    chk("R5 idle prg_ce", {31'd0, prg_rom_ce}, 32'd0);
    chk("R5 idle prg_addr", {13'd0, prg_rom_addr}, 32'd0);
    chk("R11 idle wram_ce", {31'd0, wram_ce}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].ctrl, TBL[i].lo, TBL[i].hi, TBL[i].prg, TBL[i].cpu, TBL[i].ppu, 1'b0);
      // rows cover R1 R2 R3 R4 R5 R6 R7 R8
      chk("R1-R5 prg_rom_addr", {13'd0, prg_rom_addr}, {13'd0, TBL[i].exp_prg});
      chk("R6/R7 chr_addr", {15'd0, chr_addr}, {15'd0, TBL[i].exp_chr});
      chk("R8 nt_page", {31'd0, nt_page}, {31'd0, TBL[i].exp_nt});
    end

    // R8: mirror field exposed
    drive(5'h0B, 5'h00, 5'h00, 5'h00, 16'h8000, 13'h0800, 1'b0);
    chk("R8 mirror_mode", {30'd0, mirror_mode}, 32'd3);
    chk("R8 horizontal a11", {31'd0, nt_page}, 32'd1);
    // R1: offset also on fixed bank 0 in layout 10
    drive(5'h08, 5'h10, 5'h00, 5'h05, 16'h8000, 13'h0000, 1'b0);
    chk("R1 fixed low bank plus step", {13'd0, prg_rom_addr}, 32'h40000);

    // R10/R11/R9 work RAM
    drive(5'h00, 5'h08, 5'h00, 5'h00, 16'h6123, 13'h0000, 1'b1);
    chk("R10 bank from bit3 in 8K mode", {18'd0, wram_addr}, 32'h2123);
    chk("R11 write in window", {31'd0, wram_we}, 32'd1);
    chk("R11 ce in window", {31'd0, wram_ce}, 32'd1);
    chk("R9 enabled read data", {24'd0, wram_rd_data}, 32'h5A);
    drive(5'h10, 5'h08, 5'h00, 5'h00, 16'h6123, 13'h0000, 1'b0);
    chk("R10 bank from bit4 in 4K mode (0)", {18'd0, wram_addr}, 32'h0123);
    chk("R11 no write without strobe", {31'd0, wram_we}, 32'd0);
    drive(5'h10, 5'h10, 5'h00, 5'h00, 16'h6123, 13'h0000, 1'b0);
    chk("R10 bank from bit4 in 4K mode (1)", {18'd0, wram_addr}, 32'h2123);
    drive(5'h00, 5'h00, 5'h00, 5'h10, 16'h6123, 13'h0000, 1'b1);
    chk("R9 disabled write dropped", {31'd0, wram_we}, 32'd0);
    chk("R9 disabled ce", {31'd0, wram_ce}, 32'd0);
    chk("R9 disabled read bus hold", {24'd0, wram_rd_data}, 32'hC3);
    drive(5'h00, 5'h00, 5'h00, 5'h00, 16'h8000, 13'h0000, 1'b1);
    chk("R11 rom space not wram", {31'd0, wram_we}, 32'd0);
    chk("R5 rom ce", {31'd0, prg_rom_ce}, 32'd1);
    drive(5'h00, 5'h00, 5'h00, 5'h00, 16'h5FFF, 13'h0000, 1'b0);
    chk("R11 below window", {31'd0, wram_ce}, 32'd0);
    chk("R5 below rom", {31'd0, prg_rom_ce}, 32'd0);
    drive(5'h00, 5'h00, 5'h00, 5'h00, 16'h7FFF, 13'h0000, 1'b0);
    chk("R11 window top", {31'd0, wram_ce}, 32'd1);
    chk("R10 window top addr", {18'd0, wram_addr}, 32'h1FFF);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule